// File: doc/BRIEF.md
# Serial-Bus Channel-Select Slave

This block is a slave on a two-wire serial bus (I2C style). It holds a single 8-bit control byte, and each bit of that byte enables one downstream channel. The bus clock and data lines are sampled by a faster system clock. The block never drives the data line high. It only enables an open-drain pull-down.

There is no register pointer. A write transaction carries the control byte directly after the address byte, and every further data byte in the same transaction replaces it. A read transaction returns the current byte. The byte is sent again after each master acknowledge, until the master answers with a not-acknowledge. A start or stop condition at any point abandons whatever byte is in progress.

The seven-bit slave address is the fixed prefix `1110` followed by three strap inputs. An address that does not match is not acknowledged, and the block then ignores the bus until the next start.

Top module: `i2c_chansel`

## Requirements
- R1: The block acknowledges an address byte whose seven address bits equal {1110, strap[2], strap[1], strap[0]}, sent MSB first and followed by the R/W bit (0 = write, 1 = read). It acknowledges by holding the data line low through the high phase of the ninth clock.
- R2: After an address byte that does not match, the block leaves the data line released. It ignores the following bytes, so `chan_en` keeps its value and no bit is acknowledged, until the next start.
- R3: A written byte is received MSB first and reaches `chan_en` only after the falling edge that ends its acknowledge clock. During the high phase of that acknowledge clock, `chan_en` still shows the old value.
- R4: Every data byte of a write is acknowledged, and each one replaces the control byte. After a multi-byte write, the last byte is held.
- R5: A read shifts out the control byte MSB first, one bit per clock. The block releases the data line during the master's acknowledge bit.
- R6: After a master acknowledge, the same control byte is sent again. After a master not-acknowledge, the data line stays released until a stop or start.
- R7: A stop inside a byte leaves the control byte unchanged and returns the block to idle. A repeated start inside a byte restarts address reception.
- R8: The block changes the data-line pull-down only while the clock line is low. The pull-down is stable across every clock-high phase.
- R9: A low `rst_n` sampled on a clock edge clears the control byte to 0x00, which disables all channels, and releases the data line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Synchronous active-low reset; clears the control byte |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| strap | input | 3 | Low three bits of the slave address |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| chan_en | output | 8 | Channel enables, one per control bit |

## Verification
The bench goes after the acknowledge clock of a write. A design that commits the byte too early shows the new enables while the ninth clock is still high. The bench aborts bytes with a stop and with a repeated start. A design that keeps partial shift state would load a garbage byte, or would miss the address that follows. It checks the master not-acknowledge path, where a design that keeps transmitting would hold the data line low and block the stop. It also sends near-miss addresses: a wrong prefix and a wrong strap value. A loose comparator would acknowledge these and corrupt the channel enables.

// File: rtl/i2c_chansel_pkg.sv
// Shared types for the channel-select slave.
// Assumes: one byte engine per instance; the state encoding is internal only.
package i2c_chansel_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, // waiting for a start
        ST_ADDR, // shifting in address + R/W
        ST_AACK, // driving the address acknowledge
        ST_WR,   // shifting in a control byte
        ST_WACK, // driving the data acknowledge
        ST_RD,   // shifting out the control byte
        ST_RACK, // sampling the master acknowledge
        ST_IGN   // bus ignored until next start
    } chsel_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
// Multi-stage synchronizer and edge detector for asynchronous bus lines.
// Assumes: lines idle high, so reset loads ones and no false edge appears after reset.
module i2c_line_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] stg [STAGES];
    logic [W-1:0] prev;

    // Shift raw line values through the synchronizer chain and keep last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '1;
            prev <= '1;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            prev <= stg[STAGES-1];
        end
    end

    assign lvl  = stg[STAGES-1];
    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/i2c_chansel_ctrl.sv
// Byte engine: address match, write load, read shift-out, acknowledge timing.
// Assumes: synchronized levels and single-cycle edge strobes; start/stop strobes
// never coincide with clock edges (data moves only while the clock is steady).
module i2c_chansel_ctrl
    import i2c_chansel_pkg::*;
#(
    parameter int          DW   = 8,
    parameter int          FIXW = 4,
    parameter logic [FIXW-1:0] FIX = 4'b1110,
    localparam int         SW   = DW - 1 - FIXW,
    localparam int         CW   = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_lvl,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [SW-1:0] strap,
    output logic          sda_oe,
    output logic [DW-1:0] ctrl
);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    chsel_state_e  st;
    logic [DW-1:0] sh;
    logic [CW-1:0] cnt;
    logic          flag;  // first ack-phase edge seen
    logic          rw;
    logic          mack;
    logic [DW-1:0] byte_in;

    // Byte assembled from the shift register and the bit sampled now.
    assign byte_in = {sh[DW-2:0], sda_lvl};

    // Bus state machine: all SDA drive changes happen on SCL falling strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; sh <= '0; cnt <= '0; flag <= 1'b0;
            rw <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0; ctrl <= '0;
        end else if (start_det) begin
            st <= ST_ADDR; cnt <= '0; flag <= 1'b0; sda_oe <= 1'b0;
        end else if (stop_det) begin
            st <= ST_IDLE; flag <= 1'b0; sda_oe <= 1'b0;
        end else begin
            case (st)
                ST_ADDR: if (scl_rise) begin
                    sh  <= byte_in;
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        flag <= 1'b0;
                        if (byte_in[DW-1:1] == {FIX, strap}) begin
                            rw <= sda_lvl;
                            st <= ST_AACK;
                        end else begin
                            st <= ST_IGN;
                        end
                    end
                end
                ST_AACK: if (scl_fall) begin
                    if (!flag) begin
                        sda_oe <= 1'b1; flag <= 1'b1;
                    end else begin
                        flag <= 1'b0; cnt <= '0;
                        if (rw) begin
                            st <= ST_RD; sh <= ctrl; sda_oe <= ~ctrl[DW-1];
                        end else begin
                            st <= ST_WR; sda_oe <= 1'b0;
                        end
                    end
                end
                ST_WR: if (scl_rise) begin
                    sh  <= byte_in;
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        st <= ST_WACK; flag <= 1'b0;
                    end
                end
                ST_WACK: if (scl_fall) begin
                    if (!flag) begin
                        sda_oe <= 1'b1; flag <= 1'b1;
                    end else begin
                        sda_oe <= 1'b0; flag <= 1'b0; cnt <= '0;
                        ctrl <= sh;
                        st <= ST_WR;
                    end
                end
                ST_RD: if (scl_fall) begin
                    if (cnt == LAST) begin
                        sda_oe <= 1'b0; st <= ST_RACK; flag <= 1'b0;
                    end else begin
                        sh     <= {sh[DW-2:0], 1'b0};
                        sda_oe <= ~sh[DW-2];
                        cnt    <= cnt + 1'b1;
                    end
                end
                ST_RACK: if (scl_rise) begin
                    flag <= 1'b1; mack <= ~sda_lvl;
                end else if (scl_fall && flag) begin
                    flag <= 1'b0;
                    if (mack) begin
                        st <= ST_RD; sh <= ctrl; sda_oe <= ~ctrl[DW-1]; cnt <= '0;
                    end else begin
                        st <= ST_IGN;
                    end
                end
                default: ;
            endcase
        end
    end

    // R3
    ctrl_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl != $past(ctrl)) |-> ($past(st) == ST_WACK && $past(scl_fall)));
    // R2
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE || st == ST_IGN) |-> !sda_oe);
    // R7
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st == ST_IDLE && !sda_oe));
    // R7
    start_to_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st == ST_ADDR && cnt == '0));
    // R5
    release_on_mack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RACK) |-> !sda_oe);
endmodule

// File: rtl/i2c_chansel.sv
// Top of the channel-select slave: line synchronizer, start/stop detect, byte engine.
// Assumes: clk is several times faster than the bus clock, so each bus phase
// spans more cycles than the synchronizer latency.
module i2c_chansel #(
    parameter int CH          = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_FIX_W  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    input  logic [CH-2-ADDR_FIX_W:0]   strap,
    output logic                       sda_oe,
    output logic [CH-1:0]              chan_en
);
    logic [1:0] lvl, rise, fall;
    logic       start_det, stop_det;

    i2c_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({sda_i, scl_i}),
        .lvl(lvl), .rise(rise), .fall(fall)
    );

    // Start: data falls with clock high; stop: data rises with clock high.
    assign start_det = fall[1] & lvl[0];
    assign stop_det  = rise[1] & lvl[0];

    i2c_chansel_ctrl #(.DW(CH), .FIXW(ADDR_FIX_W), .FIX(ADDR_FIX_W'(4'b1110))) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .scl_rise(rise[0]), .scl_fall(fall[0]), .sda_lvl(lvl[1]),
        .start_det(start_det), .stop_det(stop_det),
        .strap(strap), .sda_oe(sda_oe), .ctrl(chan_en)
    );

    // R8
    drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !lvl[0]);
    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (chan_en == '0 && !sda_oe));
endmodule

// File: tb/i2c_chansel_tb.sv
module i2c_chansel_tb;
    localparam int Q = 10;  // system clocks per quarter bit

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic [2:0] strap = 3'b101;
    logic sda_oe;
    logic [7:0] chan_en;
    logic sda_bus;
    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic last_smp, last_oe_a, last_oe_b;
    logic [7:0] last_en;
    logic [7:0] exp_reg = 8'h00;

    assign sda_bus = m_sda & ~sda_oe;

    always #2.5 clk = ~clk;  // 200 MHz

    i2c_chansel u_dut (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
                       .strap(strap), .sda_oe(sda_oe), .chan_en(chan_en));

    function automatic logic [7:0] addr_byte(input logic [2:0] s, input logic rw);
        return {4'b1110, s, rw};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(); scl = 1'b1; wq(); m_sda = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(); scl = 1'b1; wq(); m_sda = 1'b1; wq();
    endtask

    // One clock: drive data while low, sample mid-high, check drive stable (R8).
    task automatic bit_cycle(input logic b);
        m_sda = b; wq(); scl = 1'b1; wq();
        last_smp = sda_bus; last_oe_a = sda_oe; last_en = chan_en;
        wq(); last_oe_b = sda_oe; scl = 1'b0; wq();
        chk(last_oe_a == last_oe_b, "R8 pull-down stable in clock high",
            {7'd0, last_oe_b}, {7'd0, last_oe_a});
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack, output logic [7:0] en_in_ack);
        for (int i = 7; i >= 0; i--) bit_cycle(b[i]);
        bit_cycle(1'b1);
        ack = ~last_smp;
        en_in_ack = last_en;
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] d);
        d = '0;
        for (int i = 0; i < 8; i++) begin
            bit_cycle(1'b1);
            d = {d[6:0], last_smp};
        end
        bit_cycle(~mack);
        chk(!last_oe_a && !last_oe_b, "R5 release in master ack bit", {7'd0, last_oe_a}, 8'h00);
    endtask

    task automatic do_write(input logic [7:0] v, input string req);
        logic a;
        logic [7:0] e;
        write_byte(v, a, e);
        chk(a, req, {7'd0, a}, 8'h01);
        chk(e == exp_reg, "R3 old value during ack clock", e, exp_reg);
        exp_reg = v;
        chk(chan_en == exp_reg, "R3 new value after ack", chan_en, exp_reg);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] e, d;
        int unused;
        unused = $urandom(32'd2718);
        repeat (8) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R9 reset state
        chk(chan_en == 8'h00 && !sda_oe, "R9 reset clears", chan_en, 8'h00);

        // R1 / R3 / R4 directed write
        bus_start();
        write_byte(addr_byte(strap, 1'b0), a, e);
        chk(a, "R1 address ack", {7'd0, a}, 8'h01);
        do_write(8'hA5, "R4 data ack");
        bus_stop();

        // R5 / R6 read, repeat on ACK, silence after NACK
        bus_start();
        write_byte(addr_byte(strap, 1'b1), a, e);
        chk(a, "R1 read address ack", {7'd0, a}, 8'h01);
        read_byte(1'b1, d);
        chk(d == exp_reg, "R5 read value", d, exp_reg);
        read_byte(1'b0, d);
        chk(d == exp_reg, "R6 resend after ack", d, exp_reg);
        read_byte(1'b0, d);
        chk(d == 8'hFF && !sda_oe, "R6 released after nack", d, 8'hFF);
        bus_stop();

        // R4 multi-byte write, last wins
        bus_start();
        write_byte(addr_byte(strap, 1'b0), a, e);
        do_write(8'h3C, "R4 byte 1 ack");
        do_write(8'h81, "R4 byte 2 ack");
        do_write(8'h7E, "R4 byte 3 ack");
        bus_stop();
        chk(chan_en == 8'h7E, "R4 last byte held", chan_en, 8'h7E);

        // R2 wrong prefix and wrong strap
        bus_start();
        write_byte({4'b1111, strap, 1'b0}, a, e);
        chk(!a, "R2 wrong prefix no ack", {7'd0, a}, 8'h00);
        write_byte(8'h00, a, e);
        chk(!a && chan_en == exp_reg, "R2 data ignored", chan_en, exp_reg);
        bus_stop();
        bus_start();
        write_byte(addr_byte(strap ^ 3'b010, 1'b0), a, e);
        chk(!a, "R2 wrong strap no ack", {7'd0, a}, 8'h00);
        write_byte(8'h11, a, e);
        chk(!a && chan_en == exp_reg, "R2 data ignored strap", chan_en, exp_reg);
        bus_stop();

        // R7 stop inside a byte
        bus_start();
        write_byte(addr_byte(strap, 1'b0), a, e);
        for (int i = 0; i < 5; i++) bit_cycle(i[0]);
        bus_stop();
        chk(chan_en == exp_reg, "R7 stop mid byte", chan_en, exp_reg);
        // R7 repeated start inside a byte
        bus_start();
        write_byte(addr_byte(strap, 1'b0), a, e);
        for (int i = 0; i < 4; i++) bit_cycle(1'b1);
        bus_start();
        write_byte(addr_byte(strap, 1'b1), a, e);
        chk(a, "R7 address after repeated start", {7'd0, a}, 8'h01);
        read_byte(1'b0, d);
        chk(d == exp_reg, "R7 value kept", d, exp_reg);
        bus_stop();

        // Random mix
        for (int it = 0; it < 30; it++) begin
            int op;
            op = int'($urandom % 3);
            bus_start();
            if (op == 0) begin
                write_byte(addr_byte(strap, 1'b0), a, e);
                chk(a, "R1 random write address", {7'd0, a}, 8'h01);
                for (int k = 0; k <= int'($urandom % 3); k++)
                    do_write(8'($urandom), "R4 random data ack");
            end else if (op == 1) begin
                write_byte(addr_byte(strap, 1'b1), a, e);
                chk(a, "R1 random read address", {7'd0, a}, 8'h01);
                read_byte(1'b1, d);
                chk(d == exp_reg, "R5 random read", d, exp_reg);
                read_byte(1'b0, d);
                chk(d == exp_reg, "R6 random resend", d, exp_reg);
            end else begin
                logic [2:0] s;
                s = strap ^ 3'(1 + ($urandom % 7));
                write_byte(addr_byte(s, 1'b0), a, e);
                chk(!a, "R2 random mismatch", {7'd0, a}, 8'h00);
                write_byte(8'($urandom), a, e);
                chk(chan_en == exp_reg, "R2 random ignored", chan_en, exp_reg);
            end
            bus_stop();
        end

        // R9 reset after traffic
        bus_start();
        write_byte(addr_byte(strap, 1'b0), a, e);
        do_write(8'hF0, "R4 pre-reset write");
        bus_stop();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(chan_en == 8'h00 && !sda_oe, "R9 reset after write", chan_en, 8'h00);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule